// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

The walker reads a table of 8-byte scatter-gather descriptors from memory and turns each valid transfer entry into one address/length command for a downstream data mover. Software writes the table start address to `table_base` and pulses `start`. The walker then fetches entries one at a time over a simple request/response read port. For each entry it decodes the flags and the action code, issues a command or skips the entry, and moves on to the next slot until it reaches an entry marked as last.

A stored length of zero stands for the largest region, 65536 bytes, so the command length port is one bit wider than the stored field. The walk ends with a one-cycle `done` pulse. It can end normally, on an entry whose valid flag is clear, on an action the walker does not carry out, or when the table runs past its last slot with no end mark. A small error code and the index of the offending entry stay readable until the next start. An entry that carries the interrupt flag raises a one-cycle `irq` pulse when it retires.

Top module: `sg_desc_walker`

## Requirements
- R1: A `start` pulse while idle captures `table_base` and reads entry i at address base + 8*i, one `mem_req` pulse per entry, with i counting from 0. A `start` pulse while busy is ignored: neither the base nor the walk changes.
- R2: A descriptor arrives as one 64-bit word. Bits 15:0 hold the attribute, bits 31:16 the length and bits 63:32 the data address. In the attribute, bit 0 is valid, bit 1 is end, bit 2 is interrupt, and bits 5:4 are the action.
- R3: A valid entry with action 2'b10 produces exactly one command carrying its address and length. A stored length of 0 appears on `cmd_len` as 65536.
- R4: A valid entry with action 2'b00 produces no command. The walk continues, and the entry's end flag is still honoured.
- R5: An entry whose valid bit is clear stops the walk with error code 1 and that entry's index on `err_idx`. No command is issued for it.
- R6: A valid entry with action 2'b01 or 2'b11 stops the walk with error code 2 and that entry's index.
- R7: If entry MAX_DESC-1 retires without an end flag, the walk stops with error code 3 and index MAX_DESC-1. An end flag on that entry ends the walk normally with code 0.
- R8: When an entry with the interrupt flag retires (its command is accepted, or it is skipped), `irq` pulses for one cycle. On an end entry this pulse falls in the same cycle as `done`.
- R9: Every walk ends with a single-cycle `done` pulse, and `busy` is low in that cycle. `err_code` and `err_idx` hold their values until the next accepted start, which clears `err_code` to 0.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_len` stay unchanged.
- R11: After reset, `busy`, `done`, `irq`, `mem_req` and `cmd_valid` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (honoured only while idle) |
| table_base | input | 32 | Byte address of descriptor entry 0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| irq | output | 1 | One-cycle pulse when an entry with the interrupt flag retires |
| err_code | output | 2 | 0 none, 1 invalid entry, 2 unsupported action, 3 table overrun |
| err_idx | output | 5 | Index of the entry that ended the walk in error |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor word |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_addr | output | 32 | Transfer start address |
| cmd_len | output | 17 | Transfer length in bytes (1 to 65536) |

## Verification
The interrupt pulse and the completion pulse can fall in the same cycle. This happens when the entry marked as last also carries the interrupt flag and its command is accepted. The bench builds that table, with the mover's ready pattern stretching the handshake, and records whether `irq` was high in the very cycle `done` rose; the check fails if the two arrive apart or if `irq` is missing. Tables whose interrupt flags sit on middle or skipped entries confirm that the pulse can also appear alone, with no completion pulse beside it.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
   localparam int unsigned DESC_AW   = 32;
   localparam int unsigned DESC_LW   = 16;
   localparam int unsigned DESC_W    = 64;
   localparam int unsigned B_VALID   = 0;
   localparam int unsigned B_END     = 1;
   localparam int unsigned B_INTR    = 2;
   localparam int unsigned B_ACT_LO  = 4;

   typedef enum logic [1:0] {
      ACT_NOP  = 2'b00,
      ACT_RSV  = 2'b01,
      ACT_XFER = 2'b10,
      ACT_LINK = 2'b11
   } act_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_INVALID = 2'd1,
      ERR_ACTION  = 2'd2,
      ERR_OVERRUN = 2'd3
   } err_e;

   typedef struct packed {
      logic [DESC_AW-1:0] addr;
      logic [DESC_LW-1:0] len;
      logic [15:0]        attr;
   } desc_t;

   typedef struct packed {
      logic               valid;
      logic               last;
      logic               intr;
      act_e               act;
      logic [DESC_LW:0]   len;
      logic [DESC_AW-1:0] addr;
   } dinfo_t;
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
   import sgw_pkg::*;
#(
   parameter int unsigned MAX_DESC = 32,
   parameter int unsigned IDX_W    = $clog2(MAX_DESC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               advance,
   input  logic               capture,
   input  logic [DESC_AW-1:0] base_in,
   input  logic [DESC_W-1:0]  rdata,
   output logic [IDX_W-1:0]   idx,
   output logic               last_slot,
   output logic [DESC_AW-1:0] rd_addr,
   output desc_t              desc
);
   localparam int unsigned OFS_PAD = DESC_AW - IDX_W - 3;

   logic [DESC_AW-1:0] base_q;
   logic [IDX_W-1:0]   idx_q;
   desc_t              desc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
         desc_q <= '0;
      end else begin
         if (load) begin
            base_q <= base_in;
            idx_q  <= '0;
         end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
         end
         if (capture) desc_q <= desc_t'(rdata);
      end
   end

   assign idx       = idx_q;
   assign last_slot = (idx_q == IDX_W'(MAX_DESC - 1));
   assign rd_addr   = base_q + {{OFS_PAD{1'b0}}, idx_q, 3'b000};
   assign desc      = desc_q;
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
   import sgw_pkg::*;
#(
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  desc_t  desc,
   output dinfo_t info
);
   logic unused_attr;
   assign unused_attr = ^{desc.attr[15:6], desc.attr[3]};

   assign info.valid = desc.attr[B_VALID];
   assign info.last  = desc.attr[B_END];
   assign info.intr  = desc.attr[B_INTR];
   assign info.act   = act_e'(desc.attr[B_ACT_LO +: 2]);
   assign info.addr  = desc.addr;

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         assign info.len = (desc.len == '0) ? {1'b1, {DESC_LW{1'b0}}}
                                            : {1'b0, desc.len};
      end else begin : g_zero_raw
         assign info.len = {1'b0, desc.len};
      end
   endgenerate
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
   import sgw_pkg::*;
#(
   parameter int unsigned IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mem_rvalid,
   input  logic             cmd_ready,
   input  dinfo_t           info,
   input  logic             last_slot,
   input  logic [IDX_W-1:0] idx,
   output logic             load,
   output logic             advance,
   output logic             capture,
   output logic             mem_req,
   output logic             cmd_valid,
   output logic             busy,
   output logic             done,
   output logic             irq,
   output logic [1:0]       err_code,
   output logic [IDX_W-1:0] err_idx
);
   typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_EXEC} st_e;

   st_e              st_q, st_d;
   logic             retire, fin;
   err_e             fin_code;
   logic             done_q, irq_q;
   err_e             err_q;
   logic [IDX_W-1:0] eidx_q;

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      capture  = 1'b0;
      advance  = 1'b0;
      retire   = 1'b0;
      fin      = 1'b0;
      fin_code = ERR_NONE;
      unique case (st_q)
         S_IDLE:  if (start) begin load = 1'b1; st_d = S_FETCH; end
         S_FETCH: st_d = S_WAIT;
         S_WAIT:  if (mem_rvalid) begin capture = 1'b1; st_d = S_EXEC; end
         S_EXEC: begin
            if (!info.valid) begin
               fin = 1'b1; fin_code = ERR_INVALID;
            end else begin
               unique case (info.act)
                  ACT_XFER: retire = cmd_ready;
                  ACT_NOP:  retire = 1'b1;
                  default:  begin fin = 1'b1; fin_code = ERR_ACTION; end
               endcase
            end
            if (retire) begin
               if (info.last)     fin = 1'b1;
               else if (last_slot) begin fin = 1'b1; fin_code = ERR_OVERRUN; end
               else begin advance = 1'b1; st_d = S_FETCH; end
            end
            if (fin) st_d = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= ERR_NONE;
         eidx_q <= '0;
      end else begin
         st_q   <= st_d;
         done_q <= fin;
         irq_q  <= retire && info.intr;
         if (load) err_q <= ERR_NONE;
         else if (fin) begin
            err_q  <= fin_code;
            if (fin_code != ERR_NONE) eidx_q <= idx;
         end
      end
   end

   assign mem_req   = (st_q == S_FETCH);
   assign cmd_valid = (st_q == S_EXEC) && info.valid && (info.act == ACT_XFER);
   assign busy      = (st_q != S_IDLE);
   assign done      = done_q;
   assign irq       = irq_q;
   assign err_code  = err_q;
   assign err_idx   = eidx_q;

   p_req_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(info));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(err_code) && $stable(err_idx));
   p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
   import sgw_pkg::*;
#(
   parameter int unsigned MAX_DESC    = 32,
   parameter bit          ZERO_IS_MAX = 1'b1,
   parameter int unsigned IDX_W       = $clog2(MAX_DESC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DESC_AW-1:0] table_base,
   output logic               busy,
   output logic               done,
   output logic               irq,
   output logic [1:0]         err_code,
   output logic [IDX_W-1:0]   err_idx,
   output logic               mem_req,
   output logic [DESC_AW-1:0] mem_addr,
   input  logic               mem_rvalid,
   input  logic [DESC_W-1:0]  mem_rdata,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic [DESC_AW-1:0] cmd_addr,
   output logic [DESC_LW:0]   cmd_len
);
   generate
      if (MAX_DESC < 2 || MAX_DESC > (1 << IDX_W))
         $error("sg_desc_walker: MAX_DESC must be at least 2 and fit in IDX_W bits");
      if (IDX_W + 3 > DESC_AW)
         $error("sg_desc_walker: table offset wider than the address");
   endgenerate

   logic             load, advance, capture, last_slot;
   logic [IDX_W-1:0] idx;
   desc_t            desc;
   dinfo_t           info;

   sgw_fetch #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
      .capture(capture), .base_in(table_base), .rdata(mem_rdata),
      .idx(idx), .last_slot(last_slot), .rd_addr(mem_addr), .desc(desc)
   );

   sgw_decode #(.ZERO_IS_MAX(ZERO_IS_MAX)) u_dec (
      .desc(desc), .info(info)
   );

   sgw_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_rvalid(mem_rvalid),
      .cmd_ready(cmd_ready), .info(info), .last_slot(last_slot), .idx(idx),
      .load(load), .advance(advance), .capture(capture), .mem_req(mem_req),
      .cmd_valid(cmd_valid), .busy(busy), .done(done), .irq(irq),
      .err_code(err_code), .err_idx(err_idx)
   );

   assign cmd_addr = info.addr;
   assign cmd_len  = info.len;

   generate
      if (ZERO_IS_MAX) begin : g_len_chk
         p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_valid |-> cmd_len != '0);
      end
   endgenerate
   p_cmd_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> $stable(cmd_addr) && $stable(cmd_len));
   p_fetch_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
endmodule

// File: tb/sim_sg_desc_walker.sv
module sim_sg_desc_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] table_base = '0;
   logic        busy, done, irq, mem_req, cmd_valid;
   logic [1:0]  err_code;
   logic [4:0]  err_idx;
   logic [31:0] mem_addr, cmd_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        cmd_ready = 1'b0;
   logic [16:0] cmd_len;

   int n_tests = 0, n_fail = 0;
   logic [63:0] mem [0:127];
   logic [31:0] qa[$];
   logic [16:0] ql[$];
   int  irq_cnt;
   bit  done_seen, irq_at_done;
   int  cyc = 0;

   always #4 clk = ~clk;

   sg_desc_walker u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
      .busy(busy), .done(done), .irq(irq), .err_code(err_code),
      .err_idx(err_idx), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input int slot, input logic [15:0] attr,
                      input logic [15:0] len, input logic [31:0] addr);
      mem[slot] = {addr, len, attr};
   endtask

   task automatic expect_cmd(input logic [31:0] a, input logic [16:0] l);
      qa.push_back(a);
      ql.push_back(l);
   endtask

   // memory model: two-cycle read latency
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            logic [31:0] a;
            a = mem_addr;
            repeat (2) @(posedge clk);
            #1 mem_rvalid = 1'b1;
            mem_rdata = mem[(a >> 3) & 32'd127];
            @(posedge clk);
            #1 mem_rvalid = 1'b0;
         end
      end
   end

   // data mover ready pattern: low one cycle in three
   initial begin
      forever begin
         @(posedge clk);
         #1 cyc++;
         cmd_ready = (cyc % 3) != 0;
      end
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (cmd_valid && cmd_ready) begin
               if (qa.size() == 0) begin
                  chk(1'b0, "R3 unexpected command addr", cmd_addr, 0);
               end else begin
                  logic [31:0] ea;
                  logic [16:0] el;
                  ea = qa.pop_front();
                  el = ql.pop_front();
                  chk(cmd_addr == ea, "R3 command address", cmd_addr, ea);
                  chk(cmd_len == el, "R3 command length", cmd_len, el);
               end
            end
            if (irq) irq_cnt++;
            if (done) begin
               done_seen   = 1'b1;
               irq_at_done = irq;
               chk(!busy, "R9 busy low with done", busy, 0);
            end
         end
      end
   end

   task automatic run_walk(input logic [31:0] base, input logic [1:0] ecode,
                           input logic [4:0] eidx, input int eirq, input bit dup,
                           input string tag);
      irq_cnt   = 0;
      done_seen = 1'b0;
      @(posedge clk);
      #1 start = 1'b1;
      table_base = base;
      @(posedge clk);
      #1 start = 1'b0;
      table_base = 32'h0000_0300;
      @(negedge clk);
      chk(busy == 1'b1, {tag, " R1 busy after start"}, busy, 1);
      chk(err_code == 2'd0, {tag, " R9 error cleared at start"}, err_code, 0);
      if (dup) begin
         repeat (3) @(posedge clk);
         #1 start = 1'b1;
         @(posedge clk);
         #1 start = 1'b0;
      end
      for (int i = 0; i < 20000 && !done_seen; i++) @(negedge clk);
      chk(done_seen, {tag, " R9 walk finished"}, done_seen, 1);
      chk(err_code == ecode, {tag, " error code"}, err_code, ecode);
      if (ecode != 2'd0)
         chk(err_idx == eidx, {tag, " error index"}, err_idx, eidx);
      chk(irq_cnt == eirq, {tag, " R8 irq count"}, irq_cnt, eirq);
      chk(qa.size() == 0, {tag, " R3 missing commands"}, qa.size(), 0);
      repeat (4) @(negedge clk);
      chk(!busy && !done, {tag, " R9 idle after walk"}, {busy, done}, 0);
      chk(err_code == ecode, {tag, " R9 error code held"}, err_code, ecode);
      qa.delete();
      ql.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = '0;
      // alternate table at 0x300 (slot 96): taking it would add a stray command
      put(96, 16'h0023, 16'h0010, 32'hDEAD_0000);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !done && !irq && !mem_req && !cmd_valid, "R11 reset outputs",
          {busy, done, irq, mem_req, cmd_valid}, 0);
      chk(err_code == 2'd0, "R11 reset error code", err_code, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req, "R11 idle after reset", {busy, mem_req}, 0);

      // T1 (R2 R3 R8): single end entry with interrupt flag
      put(32, 16'h0027, 16'h0200, 32'h8000_0000);
      expect_cmd(32'h8000_0000, 17'h00200);
      run_walk(32'h100, 2'd0, 5'd0, 1, 1'b0, "T1");
      chk(irq_at_done, "R8 irq coincides with done", irq_at_done, 1);

      // T2 (R1 R3): zero length means 65536, start while busy ignored
      put(32, 16'h0021, 16'h0000, 32'h0001_0000);
      put(33, 16'h0025, 16'h0000, 32'h0002_0000);
      put(34, 16'h0023, 16'h0400, 32'h0003_0000);
      expect_cmd(32'h0001_0000, 17'h10000);
      expect_cmd(32'h0002_0000, 17'h10000);
      expect_cmd(32'h0003_0000, 17'h00400);
      run_walk(32'h100, 2'd0, 5'd0, 1, 1'b1, "T2 R1");
      chk(!irq_at_done, "R8 no irq at done without flag", irq_at_done, 0);

      // T3 (R5): invalid entry at index 2
      put(32, 16'h0021, 16'h0100, 32'h0000_1000);
      put(33, 16'h0021, 16'h0080, 32'h0000_2000);
      put(34, 16'h0022, 16'h0040, 32'h0000_3000);
      expect_cmd(32'h0000_1000, 17'h00100);
      expect_cmd(32'h0000_2000, 17'h00080);
      run_walk(32'h100, 2'd1, 5'd2, 0, 1'b0, "T3 R5");

      // T4 (R4 R8): nop entry skipped, its interrupt still pulses
      put(32, 16'h0021, 16'h0010, 32'h0000_4000);
      put(33, 16'h0005, 16'h0020, 32'h0000_5000);
      put(34, 16'h0023, 16'h0030, 32'h0000_6000);
      expect_cmd(32'h0000_4000, 17'h00010);
      expect_cmd(32'h0000_6000, 17'h00030);
      run_walk(32'h100, 2'd0, 5'd0, 1, 1'b0, "T4 R4");

      // T5 (R6): link action is unsupported
      put(32, 16'h0021, 16'h0010, 32'h0000_7000);
      put(33, 16'h0031, 16'h0010, 32'h0000_8000);
      expect_cmd(32'h0000_7000, 17'h00010);
      run_walk(32'h100, 2'd2, 5'd1, 0, 1'b0, "T5 R6");

      // T6 (R6): reserved action code 01
      put(0, 16'h0013, 16'h0010, 32'h0000_9000);
      run_walk(32'h000, 2'd2, 5'd0, 0, 1'b0, "T6 R6");

      // T7 (R7): 32 entries with no end flag
      for (int i = 0; i < 32; i++) begin
         put(i, 16'h0021, 16'(16 * i + 16), 32'(i) << 16);
         expect_cmd(32'(i) << 16, 17'(16 * i + 16));
      end
      run_walk(32'h000, 2'd3, 5'd31, 0, 1'b0, "T7 R7");

      // T8 (R7): end flag on the last slot finishes normally
      for (int i = 0; i < 32; i++) begin
         put(i, (i == 31) ? 16'h0023 : 16'h0021, 16'h0008, 32'h0100_0000 + 32'(i));
         expect_cmd(32'h0100_0000 + 32'(i), 17'h00008);
      end
      run_walk(32'h000, 2'd0, 5'd0, 0, 1'b0, "T8 R7");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule